// File: doc/BRIEF.md
# Trim-Code Register with Two-Wire Serial Target

This block is a two-wire serial (I2C) target that owns an 8-bit trim code for a current-sink DAC. Its SCL and SDA inputs are sampled on the system clock and passed through a stable-count glitch filter. It answers on SDA by enabling an open-drain pull-down. The first byte of a transfer holds a fixed 6-bit address. After the address comes one data bit, and the R/W bit comes last. This lets a write deliver a full 8-bit code in only two bytes. The final bit of the second byte selects one of two actions: load the live register, or ask the non-volatile store to keep the current register value.

A write-protect input gates both of those actions. Protected writes are still acknowledged, so the bus behaves the same either way. Reads are allowed at all times. At power-up the surrounding logic presents the stored code with a one-cycle valid strobe. The output code is then correct without any bus traffic.

Top module: `trimI2cTarget`

## Requirements
- R1: After reset, `trimCode` is 0, `sdaPullDown` is low and `progReq` is low.
- R2: A high `nvLoadValid` loads `nvLoadData` into `trimCode` on the next clock edge.
- R3: The first byte after a START is matched on its bits 7..2 (first six bits on the wire) against 100111. On a match the target pulls SDA low for the ninth clock. On a mismatch it does not pull SDA, and it ignores all traffic until the next START.
- R4: A write carries the code in two parts. Byte one is `100111`, then code bit 0, then R/W = 0. Byte two is code bits 7..1, then P. With write-protect high and P = 1, the code is loaded into `trimCode` when the following STOP is detected.
- R5: With write-protect high and P = 0, the STOP produces a single-cycle `progReq` and leaves `trimCode` unchanged. The code bits carried in that transfer are ignored.
- R6: With write-protect low, the address byte and data byte of a write are both acknowledged. `trimCode` does not change and `progReq` is not raised.
- R7: In a read, byte one has R/W = 1, and its bit 1 is a don't-care. The target then shifts out `trimCode` MSB first as one byte, whatever the write-protect level.
- R8: An update or programming request happens only when a STOP follows the acknowledged second byte. A STOP after the address byte changes nothing. So does a repeated START after the second byte.
- R9: A pulse on SCL or SDA shorter than `STABLE_LEN` clock cycles is rejected. It neither shifts a bit nor counts as START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as sampled |
| sdaIn | input | 1 | Serial data line as sampled |
| wpIn | input | 1 | Write-protect; high permits writes and programming |
| nvLoadValid | input | 1 | One-cycle strobe presenting the stored code |
| nvLoadData | input | 8 | Stored code from the non-volatile cells |
| sdaPullDown | output | 1 | Enable for the open-drain SDA pull-down |
| trimCode | output | 8 | Current trim code for the DAC |
| progReq | output | 1 | One-cycle request to program the current code |

## Verification
The bench sweeps write-then-read over codes that cover every upper-bit pattern and both values of the split-off bit 0. A design that placed the address-byte bit in the wrong position would show this directly in the read-back value. It also checks that protected transfers still get ACKs but change nothing. A design that gated the ACK on write-protect, or that dropped the gate altogether, would fail those checks. Aborted transfers are covered: STOP right after the address, and repeated START after the data byte. A target that committed at the data ACK would update in both cases. Finally, short pulses are injected on SDA while SCL is high and on SCL while it is low. An unfiltered target would either see a false START or shift in an extra bit.

// File: rtl/trimI2cPkg.sv
package trimI2cPkg;
  localparam int BYTE_W = 8;
  localparam logic [5:0] TARGET_ADDR = 6'b100111;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_DATA, S_DATA_ACK, S_PEND, S_READ, S_IGNORE
  } busState_t;

  typedef struct packed {
    logic shiftIn;      // sample filtered SDA into receive shifter
    logic loadTx;       // copy trim register into transmit shifter
    logic shiftTx;      // advance transmit shifter
    logic keepLsb;      // hold code bit 0 from the address byte
    logic commitWrite;  // load assembled code into trim register
  } dpStrobe_t;
endpackage

// File: rtl/trimLineFilter.sv
module trimLineFilter #(
  parameter int STABLE_LEN = 7,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = $clog2(STABLE_LEN + 1);

  logic [1:0] syncReg;
  logic [CNT_W-1:0] stableCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg   <= {2{RESET_VAL}};
      stableCnt <= '0;
      cleanOut  <= RESET_VAL;
    end else begin
      syncReg <= {syncReg[0], rawIn};
      if (syncReg[1] == cleanOut) begin
        stableCnt <= '0;
      end else if (stableCnt == CNT_W'(STABLE_LEN - 1)) begin
        stableCnt <= '0;
        cleanOut  <= syncReg[1];
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trimDatapath.sv
module trimDatapath
  import trimI2cPkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaF,
  input  dpStrobe_t         strobes,
  input  logic              nvLoadValid,
  input  logic [BYTE_W-1:0] nvLoadData,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic              txNext,
  output logic [BYTE_W-1:0] trimCode
);
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic              lsbHold;
  logic [BYTE_W-1:0] trimReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      lsbHold <= 1'b0;
      trimReg <= RESET_CODE;
    end else begin
      if (strobes.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaF};
      if (strobes.loadTx) txShift <= trimReg;
      else if (strobes.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (strobes.keepLsb) lsbHold <= rxShift[1];
      if (nvLoadValid) trimReg <= nvLoadData;
      else if (strobes.commitWrite) trimReg <= {rxShift[BYTE_W-1:1], lsbHold};
    end
  end

  assign rxByte   = rxShift;
  assign txMsb    = txShift[BYTE_W-1];
  assign txNext   = txShift[BYTE_W-2];
  assign trimCode = trimReg;
endmodule

// File: rtl/trimCtrl.sv
module trimCtrl
  import trimI2cPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic              wpF,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  input  logic              txNext,
  output dpStrobe_t         strobes,
  output logic              sdaPullDown,
  output logic              progReq
);
  busState_t state, nextState;
  logic [3:0] bitCnt, nextCnt;
  logic isRead, nextRead;
  logic nextPull, nextProg;
  logic sclPrev, sdaPrev;
  logic sclRise, sclFall, startEv, stopEv;

  assign sclRise = sclF & ~sclPrev;
  assign sclFall = ~sclF & sclPrev;
  assign startEv = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopEv  = sclF & sclPrev & ~sdaPrev & sdaF;

  always_comb begin
    nextState = state;
    nextCnt   = bitCnt;
    nextRead  = isRead;
    nextPull  = sdaPullDown;
    nextProg  = 1'b0;
    strobes   = '0;
    if (startEv) begin
      nextState = S_ADDR;
      nextCnt   = '0;
      nextPull  = 1'b0;
    end else if (stopEv) begin
      if (state == S_PEND && wpF) begin
        if (rxByte[0]) strobes.commitWrite = 1'b1;
        else nextProg = 1'b1;
      end
      nextState = S_IDLE;
      nextPull  = 1'b0;
    end else begin
      case (state)
        S_ADDR, S_DATA: begin
          if (sclRise && bitCnt != 4'd8) begin
            strobes.shiftIn = 1'b1;
            nextCnt = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (state == S_DATA) begin
              nextState = S_DATA_ACK;
              nextPull  = 1'b1;
            end else if (rxByte[7:2] == TARGET_ADDR) begin
              nextState      = S_ADDR_ACK;
              nextPull       = 1'b1;
              nextRead       = rxByte[0];
              strobes.keepLsb = ~rxByte[0];
              strobes.loadTx  = 1'b1;
            end else begin
              nextState = S_IDLE;
            end
          end
        end
        S_ADDR_ACK: begin
          if (sclFall) begin
            nextCnt = '0;
            if (isRead) begin
              nextState = S_READ;
              nextPull  = ~txMsb;
            end else begin
              nextState = S_DATA;
              nextPull  = 1'b0;
            end
          end
        end
        S_DATA_ACK: begin
          if (sclFall) begin
            nextState = S_PEND;
            nextPull  = 1'b0;
          end
        end
        S_READ: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              nextState = S_IGNORE;
              nextPull  = 1'b0;
            end else begin
              strobes.shiftTx = 1'b1;
              nextCnt  = bitCnt + 4'd1;
              nextPull = ~txNext;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      bitCnt      <= '0;
      isRead      <= 1'b0;
      sdaPullDown <= 1'b0;
      progReq     <= 1'b0;
      sclPrev     <= 1'b1;
      sdaPrev     <= 1'b1;
    end else begin
      state       <= nextState;
      bitCnt      <= nextCnt;
      isRead      <= nextRead;
      sdaPullDown <= nextPull;
      progReq     <= nextProg;
      sclPrev     <= sclF;
      sdaPrev     <= sdaF;
    end
  end
endmodule

// File: rtl/trimI2cTarget.sv
module trimI2cTarget
  import trimI2cPkg::*;
#(
  parameter int STABLE_LEN = 7,
  parameter logic [BYTE_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              wpIn,
  input  logic              nvLoadValid,
  input  logic [BYTE_W-1:0] nvLoadData,
  output logic              sdaPullDown,
  output logic [BYTE_W-1:0] trimCode,
  output logic              progReq
);
  localparam int LINES = 3;
  localparam logic [LINES-1:0] LINE_INIT = 3'b011;  // {wp, sda, scl}

  logic [LINES-1:0] rawLines, cleanLines;
  logic sclClean, sdaClean, wpClean;
  dpStrobe_t strobes;
  logic [BYTE_W-1:0] rxByte;
  logic txMsb, txNext;

  assign rawLines = {wpIn, sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : g_filt
    trimLineFilter #(.STABLE_LEN(STABLE_LEN), .RESET_VAL(LINE_INIT[g])) u_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[g]), .cleanOut(cleanLines[g])
    );
  end

  assign sclClean = cleanLines[0];
  assign sdaClean = cleanLines[1];
  assign wpClean  = cleanLines[2];

  trimCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclClean), .sdaF(sdaClean), .wpF(wpClean),
    .rxByte(rxByte), .txMsb(txMsb), .txNext(txNext), .strobes(strobes),
    .sdaPullDown(sdaPullDown), .progReq(progReq)
  );

  trimDatapath #(.RESET_CODE(RESET_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .sdaF(sdaClean), .strobes(strobes),
    .nvLoadValid(nvLoadValid), .nvLoadData(nvLoadData), .rxByte(rxByte),
    .txMsb(txMsb), .txNext(txNext), .trimCode(trimCode)
  );
endmodule

// File: rtl/trimI2cChecker.sv
module trimI2cChecker (
  input logic       clk,
  input logic       rstN,
  input logic       sclF,
  input logic       wpF,
  input logic       nvLoadValid,
  input logic [7:0] nvLoadData,
  input logic       sdaPullDown,
  input logic [7:0] trimCode,
  input logic       progReq
);
  // R2: stored code appears one cycle after its strobe
  p_nv_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    nvLoadValid |=> trimCode == $past(nvLoadData));

  // R5: programming request lasts one cycle
  p_prog_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    progReq |=> !progReq);

  // R6: programming only requested while write-protect permits it
  p_prog_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    progReq |-> $past(wpF));

  // R6: code changes by bus only while write-protect permits it
  p_code_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(trimCode) && !$past(nvLoadValid)) |-> $past(wpF));

  // R3: pull-down only begins while the filtered clock is low
  p_pull_scl_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullDown) |-> !sclF);
endmodule

bind trimI2cTarget trimI2cChecker u_chk (
  .clk(clk), .rstN(rstN), .sclF(sclClean), .wpF(wpClean),
  .nvLoadValid(nvLoadValid), .nvLoadData(nvLoadData),
  .sdaPullDown(sdaPullDown), .trimCode(trimCode), .progReq(progReq)
);

// File: tb/test_trimI2cTarget.sv
module test_trimI2cTarget;
  localparam int Q = 20;  // quarter bit period in clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, wpB = 1'b1;
  logic nvLoadValid = 1'b0;
  logic [7:0] nvLoadData = '0;
  logic sdaPullDown, progReq;
  logic [7:0] trimCode;
  logic sdaLine;
  int checks = 0, errors = 0, progCount = 0;

  always #4 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullDown;

  trimI2cTarget i_trimI2cTarget (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .wpIn(wpB),
    .nvLoadValid(nvLoadValid), .nvLoadData(nvLoadData),
    .sdaPullDown(sdaPullDown), .trimCode(trimCode), .progReq(progReq)
  );

  always @(posedge clk) if (rstN && progReq === 1'b1) progCount++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic startCond();
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(Q + 4);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(Q); sclM = 1'b1; tick(2 * Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
    acked = (sdaLine == 1'b0);
    tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic readByte(output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sclM = 1'b1; tick(Q); b[i] = sdaLine; tick(Q); sclM = 1'b0; tick(Q);
    end
    sendBit(1'b1);  // master NACK
  endtask

  task automatic writeTxn(input logic [7:0] code, input logic p, output logic a1, output logic a2);
    startCond();
    sendByte({6'b100111, code[0], 1'b0}, a1);
    sendByte({code[7:1], p}, a2);
    stopCond();
  endtask

  task automatic readTxn(input logic dc, output logic [7:0] code, output logic a1);
    startCond();
    sendByte({6'b100111, dc, 1'b1}, a1);
    readByte(code);
    stopCond();
  endtask

  // address byte with an SDA glitch in bit 7 and an SCL glitch in bit 4
  task automatic sendGlitchyAddr(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i];
      if (i == 4) begin
        tick(8); sclM = 1'b1; tick(3); sclM = 1'b0; tick(Q - 11);
      end else tick(Q);
      sclM = 1'b1;
      if (i == 7) begin
        tick(8); sdaM = 1'b0; tick(3); sdaM = b[i]; tick(2 * Q - 11);
      end else tick(2 * Q);
      sclM = 1'b0; tick(Q);
    end
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
    acked = (sdaLine == 1'b0);
    tick(Q); sclM = 1'b0; tick(Q);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a1, a2;
    logic [7:0] rd;
    int p0;
    tick(5);
    rstN = 1'b1;
    tick(20);
    check("R1", "trimCode after reset", trimCode, 8'h00);
    check("R1", "pull-down after reset", sdaPullDown, 0);
    check("R1", "progReq after reset", progCount, 0);

    nvLoadData = 8'hA5; nvLoadValid = 1'b1; tick(1); nvLoadValid = 1'b0; nvLoadData = 8'h00;
    check("R2", "power-up load", trimCode, 8'hA5);
    readTxn(1'b0, rd, a1);
    check("R7", "read after load", rd, 8'hA5);

    // sweep: every upper-bit pattern, both values of bit 0
    for (int i = 0; i < 32; i++) begin
      logic [7:0] code;
      code = {i[4:0], i[2:0] ^ 3'b101};
      writeTxn(code, 1'b1, a1, a2);
      check("R3", "address ACK on write", a1, 1);
      check("R4", "data ACK on write", a2, 1);
      check("R4", "code after write", trimCode, code);
      readTxn(i[0], rd, a1);
      check("R3", "address ACK on read", a1, 1);
      check("R7", "read-back code", rd, code);
    end

    // program request, code bits ignored
    writeTxn(8'h3C, 1'b1, a1, a2);
    p0 = progCount;
    writeTxn(8'hFF, 1'b0, a1, a2);
    check("R5", "program request count", progCount - p0, 1);
    check("R5", "code unchanged by program", trimCode, 8'h3C);

    // write-protect low
    wpB = 1'b0; tick(30);
    writeTxn(8'h99, 1'b1, a1, a2);
    check("R6", "protected address ACK", a1, 1);
    check("R6", "protected data ACK", a2, 1);
    check("R6", "protected write ignored", trimCode, 8'h3C);
    p0 = progCount;
    writeTxn(8'h99, 1'b0, a1, a2);
    check("R6", "protected program ignored", progCount - p0, 0);
    readTxn(1'b1, rd, a1);
    check("R7", "read while protected", rd, 8'h3C);
    wpB = 1'b1; tick(30);

    // address mismatch
    startCond();
    sendByte(8'b1001_1000, a1);
    check("R3", "mismatch NACK", a1, 0);
    sendByte(8'h55, a2);
    check("R3", "ignored byte NACK", a2, 0);
    stopCond();
    check("R3", "mismatch leaves code", trimCode, 8'h3C);

    // STOP after address only
    startCond();
    sendByte({6'b100111, 1'b1, 1'b0}, a1);
    stopCond();
    check("R8", "early stop leaves code", trimCode, 8'h3C);

    // repeated START after data byte, then read
    startCond();
    sendByte({6'b100111, 1'b0, 1'b0}, a1);
    sendByte({7'h7F, 1'b1}, a2);
    check("R8", "data ACK before restart", a2, 1);
    startCond();
    sendByte({6'b100111, 1'b0, 1'b1}, a1);
    readByte(rd);
    stopCond();
    check("R8", "read after restart", rd, 8'h3C);
    check("R8", "restart leaves code", trimCode, 8'h3C);

    // glitches on both lines
    startCond();
    sendGlitchyAddr({6'b100111, 1'b1, 1'b0}, a1);
    sendByte(8'b0110_1001, a2);
    stopCond();
    check("R9", "ACK despite glitches", a1, 1);
    check("R9", "code despite glitches", trimCode, 8'h69);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule